// File: doc/BRIEF.md
# Virtual Interrupt List Register Unit

This block holds the small bank of list entries that a hypervisor loads to present virtual interrupts to the virtual processor that is currently scheduled. Each entry carries:

- a virtual interrupt number;
- an urgency value, where a lower number is more urgent;
- a group bit, which picks the fast or the normal interrupt line;
- a flag marking the entry as backed by a physical interrupt;
- a two-bit lifecycle code.

Each cycle the block finds the most urgent pending entry among the enabled groups. It compares that entry against the guest's priority threshold and drives exactly one of the two virtual interrupt lines. It then tracks the entry through acknowledge and completion by the guest.

A configuration port reads and writes any entry as one 22-bit word, so the bank can be saved and restored exactly when the virtual CPU is switched out. The word layout is, from least significant bit up:

| Bits | Field |
|------|-------|
| [1:0] | state |
| [11:2] | interrupt number |
| [19:12] | urgency |
| [20] | group |
| [21] | physical-backing flag |

The state codes are:

| Code | Meaning |
|------|---------|
| 00 | empty |
| 01 | pending |
| 10 | active |
| 11 | pending and active |

A level maintenance output tells the hypervisor two things. It rises when enough entries are free to refill. It also rises, and stays raised, after a completion that named no active entry.

Top module: `virq_list_unit`

## Requirements
- R1: After synchronous reset every entry reads as all zeros (state 00). Both interrupt lines are low, the acknowledge number is 1023, and the completion-miss condition is clear.
- R2: A configuration write stores the 22-bit word at the addressed index, and `cfg_rdata` returns that word unchanged. The layout is state [1:0], number [11:2], urgency [19:12], group [20], physical flag [21].
- R3: A write of state 11 to an entry whose physical flag is 1 is stored as state 01.
- R4: Only entries with the pending bit set (state 01 or 11) whose group is enabled are candidates. The winner is the candidate with the numerically lowest urgency, and ties go to the lowest index. Entries in state 00 or 10 are never chosen.
- R5: The winner is signalled only when its urgency is strictly below `pri_thresh`. A group 0 winner drives `vfiq_o` and a group 1 winner drives `virq_o`, never both at once.
- R6: `ack_id` shows the signalled winner's number, or 1023 when nothing is signalled. An acknowledge moves the signalled entry from 01 to 10, or from 11 to 10. An acknowledge with nothing signalled changes no entry.
- R7: A completion clears the active bit of the lowest-index entry whose number matches and whose active bit is set: 10 becomes 00 and 11 becomes 01.
- R8: A completion that matches no active entry sets a sticky miss condition, which only reset clears.
- R9: `maint_irq` equals (`maint_en` and at least 2 entries in state 00) or the miss condition.
- R10: An acknowledge and a completion in the same cycle both take effect, judged on the states before the edge, so an entry in 11 hit by both ends in 10. A configuration write to an entry overrides any acknowledge or completion to that same entry in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | write enable for the configuration port |
| cfg_idx | input | 4 | entry index for read and write |
| cfg_wdata | input | 22 | entry word to write |
| cfg_rdata | output | 22 | entry word at `cfg_idx` |
| pri_thresh | input | 8 | guest priority threshold |
| grp_en | input | 2 | bit 0 enables group 0, bit 1 enables group 1 |
| maint_en | input | 1 | enables the free-entry maintenance condition |
| ack_req | input | 1 | guest acknowledge strobe |
| ack_id | output | 10 | number returned by an acknowledge this cycle |
| eoi_req | input | 1 | guest completion strobe |
| eoi_id | input | 10 | number being completed |
| virq_o | output | 1 | virtual normal interrupt line |
| vfiq_o | output | 1 | virtual fast interrupt line |
| maint_irq | output | 1 | maintenance interrupt, level |

## Verification
Acknowledge and completion can fall in the same cycle, even on the same entry. Either one can also coincide with a configuration write to the entry it touches. The random phase draws interrupt numbers from a set of eight, so all three collide often, and one directed case hits an entry in state 11 with both strobes at once. A bench model computes every entry's next state from the pre-edge states alone, applying write precedence first. Readback through the configuration port then judges the result.

// File: rtl/virq_pkg.sv
package virq_pkg;

    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        LR_EMPTY = 2'b00,
        LR_PEND  = 2'b01,
        LR_ACT   = 2'b10,
        LR_BOTH  = 2'b11
    } lr_state_e;

    typedef struct packed {
        logic              hw;
        logic              grp;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   vid;
        lr_state_e         st;
    } lr_entry_t;

    localparam int LR_W = $bits(lr_entry_t);

    // physically backed entries may not hold pending and active together
    function automatic lr_entry_t sanitize(input lr_entry_t e);
        lr_entry_t r;
        r = e;
        if (e.hw && e.st == LR_BOTH) r.st = LR_PEND;
        return r;
    endfunction

endpackage

// File: rtl/virq_lr_slot.sv
module virq_lr_slot
    import virq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  lr_entry_t wr_val,
    input  logic      ack_hit,
    input  logic      eoi_hit,
    output lr_entry_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (wr_en) begin
            cur <= sanitize(wr_val);
        end else if (ack_hit || eoi_hit) begin
            // bit1 = active, bit0 = pending
            cur.st <= lr_state_e'({(cur.st[1] & ~eoi_hit) | ack_hit,
                                   cur.st[0] & ~ack_hit});
        end
    end

    assert_hw_never_both_R3: assert property (@(posedge clk) disable iff (rst)
        cur.hw |-> cur.st != LR_BOTH);

    assert_ack_makes_active_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !wr_en) |=> (cur.st == LR_ACT));

endmodule

// File: rtl/virq_pick.sv
module virq_pick
    import virq_pkg::*;
#(
    parameter int NUM_LR = 16,
    localparam int IDX_W = $clog2(NUM_LR),
    localparam int CNT_W = $clog2(NUM_LR + 1)
)(
    input  logic                   clk,
    input  logic                   rst,
    input  lr_entry_t [NUM_LR-1:0] lrs,
    input  logic [1:0]             grp_en,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx,
    output lr_entry_t              win,
    output logic [CNT_W-1:0]       empty_cnt
);

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win       = '0;
        empty_cnt = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (lrs[i].st == LR_EMPTY) empty_cnt = empty_cnt + CNT_W'(1);
            // strict compare keeps the lowest index on ties
            if (lrs[i].st[0] && grp_en[lrs[i].grp] &&
                (!win_valid || lrs[i].prio < win.prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win       = lrs[i];
            end
        end
    end

    assert_winner_pending_R4: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (lrs[win_idx].st[0] && grp_en[lrs[win_idx].grp]));

endmodule

// File: rtl/virq_eoi_match.sv
module virq_eoi_match
    import virq_pkg::*;
#(
    parameter int NUM_LR = 16,
    localparam int IDX_W = $clog2(NUM_LR)
)(
    input  lr_entry_t [NUM_LR-1:0] lrs,
    input  logic [ID_W-1:0]        eoi_id,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (!found && lrs[i].st[1] && lrs[i].vid == eoi_id) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/virq_list_unit.sv
module virq_list_unit
    import virq_pkg::*;
#(
    parameter int NUM_LR    = 16,
    parameter int MAINT_MIN = 2,
    localparam int IDX_W = $clog2(NUM_LR),
    localparam int CNT_W = $clog2(NUM_LR + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [LR_W-1:0]   cfg_wdata,
    output logic [LR_W-1:0]   cfg_rdata,
    input  logic [PRIO_W-1:0] pri_thresh,
    input  logic [1:0]        grp_en,
    input  logic              maint_en,
    input  logic              ack_req,
    output logic [ID_W-1:0]   ack_id,
    input  logic              eoi_req,
    input  logic [ID_W-1:0]   eoi_id,
    output logic              virq_o,
    output logic              vfiq_o,
    output logic              maint_irq
);

    lr_entry_t [NUM_LR-1:0] lrs;
    lr_entry_t              win;
    logic                   win_valid;
    logic [IDX_W-1:0]       win_idx;
    logic [CNT_W-1:0]       empty_cnt;
    logic                   eoi_found;
    logic [IDX_W-1:0]       eoi_idx;
    logic                   fire;
    logic                   eoi_miss;

    genvar g;
    generate
        for (g = 0; g < NUM_LR; g++) begin : g_slot
            virq_lr_slot u_slot (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (cfg_we && cfg_idx == IDX_W'(g)),
                .wr_val  (lr_entry_t'(cfg_wdata)),
                .ack_hit (ack_req && fire && win_idx == IDX_W'(g)),
                .eoi_hit (eoi_req && eoi_found && eoi_idx == IDX_W'(g)),
                .cur     (lrs[g])
            );
        end
    endgenerate

    virq_pick #(.NUM_LR(NUM_LR)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .lrs       (lrs),
        .grp_en    (grp_en),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win       (win),
        .empty_cnt (empty_cnt)
    );

    virq_eoi_match #(.NUM_LR(NUM_LR)) u_eoi (
        .lrs    (lrs),
        .eoi_id (eoi_id),
        .found  (eoi_found),
        .idx    (eoi_idx)
    );

    assign fire      = win_valid && (win.prio < pri_thresh);
    assign virq_o    = fire && win.grp;
    assign vfiq_o    = fire && !win.grp;
    assign ack_id    = fire ? win.vid : SPURIOUS_ID;
    assign cfg_rdata = lrs[cfg_idx];

    always_ff @(posedge clk) begin
        if (rst)                         eoi_miss <= 1'b0;
        else if (eoi_req && !eoi_found)  eoi_miss <= 1'b1;
    end

    assign maint_irq = (maint_en && empty_cnt >= CNT_W'(MAINT_MIN)) || eoi_miss;

    assert_lines_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(virq_o && vfiq_o));

    assert_quiet_is_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        !(virq_o || vfiq_o) |-> ack_id == SPURIOUS_ID);

    assert_miss_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        eoi_miss |=> eoi_miss);

    assert_miss_raises_maint_R9: assert property (@(posedge clk) disable iff (rst)
        eoi_miss |-> maint_irq);

endmodule

// File: tb/virq_list_unit_tb_top.sv
module virq_list_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [21:0] cfg_wdata;
    logic [21:0] cfg_rdata;
    logic [7:0]  pri_thresh;
    logic [1:0]  grp_en;
    logic        maint_en;
    logic        ack_req;
    logic [9:0]  ack_id;
    logic        eoi_req;
    logic [9:0]  eoi_id;
    logic        virq_o, vfiq_o, maint_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    virq_list_unit dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pri_thresh(pri_thresh),
        .grp_en(grp_en), .maint_en(maint_en), .ack_req(ack_req), .ack_id(ack_id),
        .eoi_req(eoi_req), .eoi_id(eoi_id), .virq_o(virq_o), .vfiq_o(vfiq_o),
        .maint_irq(maint_irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [21:0] m_lr [16];
    logic        m_miss;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] mk(input bit hw, input bit grp, input logic [7:0] prio,
                                       input logic [9:0] vid, input logic [1:0] st);
        return {hw, grp, prio, vid, st};
    endfunction

    function automatic int pick();
        int best = -1;
        for (int i = 0; i < 16; i++)
            if (m_lr[i][0] && grp_en[m_lr[i][20]] &&
                (best < 0 || m_lr[i][19:12] < m_lr[best][19:12])) best = i;
        return best;
    endfunction

    function automatic int empties();
        int c = 0;
        for (int i = 0; i < 16; i++) if (m_lr[i][1:0] == 2'b00) c++;
        return c;
    endfunction

    task automatic do_reset();
        rst = 1'b1; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; ack_req = 0;
        eoi_req = 0; eoi_id = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) m_lr[i] = '0;
        m_miss = 1'b0;
    endtask

    // one cycle: drive, check combinational outputs vs model, clock, update model
    task automatic step(input bit we, input int widx, input logic [21:0] wval,
                        input bit ack, input bit eoi, input logic [9:0] eid);
        int sel, eidx;
        bit fire;
        logic [21:0] nxt [16];
        cfg_we = we; cfg_idx = 4'(widx); cfg_wdata = wval;
        ack_req = ack; eoi_req = eoi; eoi_id = eid;
        #1;
        sel  = pick();
        fire = (sel >= 0) && (m_lr[sel][19:12] < pri_thresh);
        check("R5 virq", 32'(virq_o), 32'(fire && m_lr[sel][20]));
        check("R5 vfiq", 32'(vfiq_o), 32'(fire && !m_lr[sel][20]));
        check("R4/R6 ack_id", 32'(ack_id), fire ? 32'(m_lr[sel][11:2]) : 32'd1023);
        check("R9 maint", 32'(maint_irq), 32'((maint_en && empties() >= 2) || m_miss));
        check("R2 readback", 32'(cfg_rdata), 32'(m_lr[widx]));
        eidx = -1;
        for (int i = 15; i >= 0; i--)
            if (m_lr[i][1] && m_lr[i][11:2] == eid) eidx = i;
        for (int i = 0; i < 16; i++) begin
            bit ah, eh;
            nxt[i] = m_lr[i];
            if (we && i == widx) begin
                nxt[i] = wval;
                if (wval[21] && wval[1:0] == 2'b11) nxt[i][1:0] = 2'b01;
            end else begin
                ah = ack && fire && i == sel;
                eh = eoi && i == eidx;
                nxt[i][1:0] = {(m_lr[i][1] & ~eh) | ah, m_lr[i][0] & ~ah};
            end
        end
        if (eoi && eidx < 0) m_miss = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 16; i++) m_lr[i] = nxt[i];
        cfg_we = 0; ack_req = 0; eoi_req = 0;
    endtask

    task automatic expect_rd(input int idx, input logic [21:0] exp, input string req);
        cfg_idx = 4'(idx);
        #1;
        check(req, 32'(cfg_rdata), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        pri_thresh = 8'hFF; grp_en = 2'b11; maint_en = 1'b1;
        do_reset();

        // R1: reset state
        #1;
        check("R1 virq", 32'(virq_o), 0);
        check("R1 vfiq", 32'(vfiq_o), 0);
        check("R1 ack_id", 32'(ack_id), 32'd1023);
        check("R1/R9 maint with empties", 32'(maint_irq), 1);
        maint_en = 1'b0; #1;
        check("R1 miss clear", 32'(maint_irq), 0);
        for (int i = 0; i < 16; i += 5) expect_rd(i, 22'h0, "R1 entry zero");

        // R3 and R2
        step(1, 3, mk(1, 1, 8'h40, 10'd33, 2'b11), 0, 0, 0);
        expect_rd(3, mk(1, 1, 8'h40, 10'd33, 2'b01), "R3 hw both stored pending");
        step(1, 5, mk(0, 0, 8'h40, 10'd55, 2'b11), 0, 0, 0);
        expect_rd(5, mk(0, 0, 8'h40, 10'd55, 2'b11), "R2 exact word");

        // R4 tie: 3 and 5 equal urgency -> index 3 wins
        step(0, 3, 0, 0, 0, 0);
        check("R4 tie lowest index", 32'(ack_id), 32'd33);
        // R5 threshold equal blocks
        pri_thresh = 8'h40;
        step(0, 3, 0, 0, 0, 0);
        check("R5 equal threshold blocks", 32'(virq_o | vfiq_o), 0);
        // R6 spurious ack changes nothing
        step(0, 3, 0, 1, 0, 0);
        expect_rd(3, mk(1, 1, 8'h40, 10'd33, 2'b01), "R6 spurious ack no change");
        pri_thresh = 8'hFF;
        // R5 group select: disable group 1 -> entry 5 (group 0) on vfiq
        grp_en = 2'b01;
        step(0, 5, 0, 0, 0, 0);
        check("R5 group0 on vfiq", 32'(vfiq_o), 1);
        // R6 ack 11 -> 10
        step(0, 5, 0, 1, 0, 0);
        expect_rd(5, mk(0, 0, 8'h40, 10'd55, 2'b10), "R6 ack both to active");
        grp_en = 2'b11;
        // R7 eoi 10 -> 00
        step(0, 5, 0, 0, 1, 10'd55);
        expect_rd(5, mk(0, 0, 8'h40, 10'd55, 2'b00), "R7 eoi active to empty");
        // R10 ack and eoi same cycle on state 11 entry
        step(1, 0, mk(0, 1, 8'h01, 10'd7, 2'b11), 0, 0, 0);
        step(0, 0, 0, 1, 1, 10'd7);
        expect_rd(0, mk(0, 1, 8'h01, 10'd7, 2'b10), "R10 ack+eoi gives active");
        // R10 write beats ack on same entry
        step(1, 1, mk(0, 1, 8'h00, 10'd9, 2'b01), 0, 0, 0);
        step(1, 1, mk(0, 0, 8'h22, 10'd11, 2'b01), 1, 0, 0);
        expect_rd(1, mk(0, 0, 8'h22, 10'd11, 2'b01), "R10 write overrides ack");

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [21:0] w;
            if (n % 50 == 0) begin
                grp_en   = 2'($urandom);
                maint_en = 1'($urandom);
                pri_thresh = 8'($urandom_range(16, 255));
            end
            w = mk(1'($urandom), 1'($urandom), 8'(($urandom % 4) * 16),
                   10'($urandom % 8), 2'($urandom));
            step(($urandom % 2) == 0, int'($urandom % 16), w,
                 ($urandom % 5) < 2, ($urandom % 5) < 2, 10'($urandom % 8));
        end
        for (int i = 0; i < 16; i++) step(0, i, 0, 0, 0, 0);

        // R8: miss is sticky regardless of maint_en
        do_reset();
        maint_en = 1'b0;
        step(0, 0, 0, 0, 1, 10'd300);
        #1;
        check("R8 miss raises maint", 32'(maint_irq), 1);
        repeat (3) step(0, 0, 0, 0, 0, 0);
        check("R8 miss sticky", 32'(maint_irq), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule